// File: doc/BRIEF.md
# Bus Interrupter with Cause Code Latch and Trigger Pair Router

This block turns a pulsed, active-low interrupt request from user logic into an assertion of one of seven active-low bus interrupt lines. The line is chosen by a configuration level from 1 to 7, and level 0 disables the interrupter. When the request input falls, the block captures a 3-bit cause code from the user. That code is kept in an interrupt status register and is returned in the status/ID word during the acknowledge cycle for the chosen level. The line stays asserted until that acknowledge happens.

The highest cause input has a second use. When the reset-enable configuration bit is set, it acts as an active-low board reset, and the captured cause bit 2 reads as zero.

The block also routes one pair of adjacent bus trigger lines to user logic. The even line of the pair is the input to the user and the odd line is the output from the user. The input waveform is passed straight through. The output drives its line low only while the user asserts it.

Top module: `irq_cause_top`

## Requirements
- R1: After reset, all bus interrupt lines are released (all ones), nothing is pending, no response is valid and the captured cause reads 0.
- R2: On a clock edge where `usr_irq_ni` is low, was high at the previous edge, nothing is pending and `cfg_level_i` is between 1 and 7, the block captures that level. From the next cycle, only bit level-1 of `bus_irq_no` is low.
- R3: In that same cycle the cause inputs are captured, with `usr_cause_i[0]` as the LSB. They appear on `stat_cause_o`, and `stat_pend_o` goes high, from the next cycle.
- R4: A falling request while `cfg_level_i` is 0 leaves nothing pending and every line released.
- R5: A falling request while an interrupt is pending changes neither the captured cause nor the asserted line.
- R6: An acknowledge (`iack_i` high) whose `iack_level_i` equals the pending level produces a response on the next cycle. `resp_valid_o` is high for exactly one cycle, and `resp_word_o` holds 0 in bits 15:11, the cause in bits 10:8 and `logical_id_i` in bits 7:0. In that same cycle the line is released and the pending flag clears.
- R7: An acknowledge at any other level, or one with nothing pending, gives no response and leaves the pending state unchanged.
- R8: While `cfg_rst_en_i` is 1, `board_rst_o` equals the inverse of `usr_cause_i[2]` within the same cycle, and a captured cause has bit 2 forced to 0. While `cfg_rst_en_i` is 0, `board_rst_o` is 0.
- R9: `usr_trg_in_no` equals `ttl_trg_ni[2*cfg_trg_pair_i]` combinationally.
- R10: `ttl_trg_no[2*cfg_trg_pair_i+1]` equals `usr_trg_out_ni` combinationally, and every other bit of `ttl_trg_no` is 1.
- R11: Holding `usr_irq_ni` low does not raise a new interrupt. Only a high-to-low change does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_level_i | input | 3 | Interrupt level 1..7; 0 disables |
| cfg_rst_en_i | input | 1 | Cause bit 2 acts as active-low board reset |
| cfg_trg_pair_i | input | 2 | Trigger pair select (input line 2n, output line 2n+1) |
| logical_id_i | input | 8 | Module ID returned in the response word |
| usr_irq_ni | input | 1 | User interrupt request, active low, edge detected |
| usr_cause_i | input | 3 | User cause code, bit 0 is the LSB |
| iack_i | input | 1 | Acknowledge cycle strobe, one clock |
| iack_level_i | input | 3 | Level being acknowledged |
| bus_irq_no | output | 7 | Bus interrupt lines, bit k is level k+1, active low |
| stat_pend_o | output | 1 | Interrupt pending |
| stat_cause_o | output | 3 | Captured cause code |
| resp_valid_o | output | 1 | Response word valid, one clock |
| resp_word_o | output | 16 | Status/ID response word |
| board_rst_o | output | 1 | Board reset request, active high |
| ttl_trg_ni | input | 8 | Bus trigger lines, sensed |
| ttl_trg_no | output | 8 | Bus trigger drive, 1 = released |
| usr_trg_in_no | output | 1 | Selected input trigger to user |
| usr_trg_out_ni | input | 1 | User output trigger, active low |

## Verification
The interrupt line, the pending flag and the captured cause change at the first clock edge where the falling request is sampled. The response pulse and the line release appear at the first edge after a matching acknowledge. The bench drives inputs on the falling clock edge and updates its model at the following rising edge. It compares the registered outputs just before the next falling edge, so each of these results is checked exactly one cycle after its stimulus. The trigger routing and the board reset are combinational, so they are checked 1 ns after the inputs change, before the clock edge.

// File: rtl/irq_cause_pkg.sv
package irq_cause_pkg;
  localparam int CAUSE_W = 3;
  localparam int ID_W    = 8;
  localparam int WORD_W  = 16;
  localparam int RSVD_W  = WORD_W - CAUSE_W - ID_W;

  typedef logic [CAUSE_W-1:0] cause_t;

  typedef struct packed {
    logic [RSVD_W-1:0] rsvd;
    cause_t            cause;
    logic [ID_W-1:0]   id;
  } resp_t;
endpackage

// File: rtl/irq_capture.sv
module irq_capture
  import irq_cause_pkg::*;
#(
  parameter int LVL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             usr_irq_ni,
  input  cause_t           usr_cause_i,
  input  logic [LVL_W-1:0] cfg_level_i,
  input  logic             cfg_rst_en_i,
  input  logic             clr_i,
  output logic             pend_o,
  output logic [LVL_W-1:0] lvl_o,
  output cause_t           cause_o,
  output logic             board_rst_o
);
  logic   irq_q;
  logic   fall;
  logic   take;
  cause_t cause_in;

  assign fall = irq_q & ~usr_irq_ni;
  assign take = fall & ~pend_o & (cfg_level_i != '0) & ~clr_i;

  // top cause bit doubles as reset input
  always_comb begin
    cause_in = usr_cause_i;
    if (cfg_rst_en_i) cause_in[CAUSE_W-1] = 1'b0;
  end

  assign board_rst_o = cfg_rst_en_i & ~usr_cause_i[CAUSE_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q   <= 1'b1;
      pend_o  <= 1'b0;
      lvl_o   <= '0;
      cause_o <= '0;
    end else begin
      irq_q <= usr_irq_ni;
      if (clr_i) begin
        pend_o <= 1'b0;
      end else if (take) begin
        pend_o  <= 1'b1;
        lvl_o   <= cfg_level_i;
        cause_o <= cause_in;
      end
    end
  end

  p_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take |=> pend_o && lvl_o != '0);
  p_cause_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_o |=> $stable(cause_o));
  p_lvl_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fall && !pend_o && cfg_level_i == '0) |=> !pend_o);
  p_rst_cause_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && cfg_rst_en_i) |=> !cause_o[CAUSE_W-1]);
  p_no_level_retrig_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pend_o && !irq_q && !usr_irq_ni) |=> !pend_o);
endmodule

// File: rtl/irq_ack.sv
module irq_ack
  import irq_cause_pkg::*;
#(
  parameter int LVL_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              iack_i,
  input  logic [LVL_W-1:0]  iack_level_i,
  input  logic              pend_i,
  input  logic [LVL_W-1:0]  lvl_i,
  input  cause_t            cause_i,
  input  logic [ID_W-1:0]   id_i,
  output logic              clr_o,
  output logic              resp_valid_o,
  output resp_t             resp_word_o
);
  assign clr_o = iack_i & pend_i & (iack_level_i == lvl_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      resp_valid_o <= 1'b0;
      resp_word_o  <= '0;
    end else begin
      resp_valid_o <= clr_o;
      if (clr_o) begin
        resp_word_o.rsvd  <= '0;
        resp_word_o.cause <= cause_i;
        resp_word_o.id    <= id_i;
      end
    end
  end

  p_resp_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_o |=> resp_valid_o && !pend_i);
  p_resp_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |=> !resp_valid_o);
  p_no_resp_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iack_i && pend_i && iack_level_i != lvl_i) |=> !resp_valid_o && pend_i);
endmodule

// File: rtl/trg_pair_router.sv
module trg_pair_router #(
  parameter int N_TRG  = 8,
  parameter int PAIR_W = $clog2(N_TRG / 2)
) (
  input  logic [PAIR_W-1:0] pair_sel_i,
  input  logic [N_TRG-1:0]  ttl_trg_ni,
  output logic [N_TRG-1:0]  ttl_trg_no,
  input  logic              usr_trg_out_ni,
  output logic              usr_trg_in_no
);
  localparam int N_PAIR = N_TRG / 2;

  assign usr_trg_in_no = ttl_trg_ni[{pair_sel_i, 1'b0}];

  for (genvar g = 0; g < N_PAIR; g++) begin : g_pair
    assign ttl_trg_no[2*g]   = 1'b1;
    assign ttl_trg_no[2*g+1] = (pair_sel_i == PAIR_W'(g)) ? usr_trg_out_ni : 1'b1;
  end

  always_comb begin
    a_single_drive_r10: assert ($countones(~ttl_trg_no) <= 1);
  end
endmodule

// File: rtl/irq_cause_top.sv
module irq_cause_top
  import irq_cause_pkg::*;
#(
  parameter int N_LVL = 7,
  parameter int N_TRG = 8,
  parameter int LVL_W = $clog2(N_LVL + 1),
  parameter int PAIR_W = $clog2(N_TRG / 2)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [LVL_W-1:0]   cfg_level_i,
  input  logic               cfg_rst_en_i,
  input  logic [PAIR_W-1:0]  cfg_trg_pair_i,
  input  logic [ID_W-1:0]    logical_id_i,
  input  logic               usr_irq_ni,
  input  logic [CAUSE_W-1:0] usr_cause_i,
  input  logic               iack_i,
  input  logic [LVL_W-1:0]   iack_level_i,
  output logic [N_LVL-1:0]   bus_irq_no,
  output logic               stat_pend_o,
  output logic [CAUSE_W-1:0] stat_cause_o,
  output logic               resp_valid_o,
  output logic [WORD_W-1:0]  resp_word_o,
  output logic               board_rst_o,
  input  logic [N_TRG-1:0]   ttl_trg_ni,
  output logic [N_TRG-1:0]   ttl_trg_no,
  output logic               usr_trg_in_no,
  input  logic               usr_trg_out_ni
);
  logic             pend;
  logic [LVL_W-1:0] lvl;
  cause_t           cause;
  logic             clr;
  resp_t            resp;

  irq_capture #(.LVL_W(LVL_W)) u_cap (
    .clk_i, .rst_ni, .usr_irq_ni, .usr_cause_i, .cfg_level_i, .cfg_rst_en_i,
    .clr_i(clr), .pend_o(pend), .lvl_o(lvl), .cause_o(cause), .board_rst_o
  );

  irq_ack #(.LVL_W(LVL_W)) u_ack (
    .clk_i, .rst_ni, .iack_i, .iack_level_i, .pend_i(pend), .lvl_i(lvl),
    .cause_i(cause), .id_i(logical_id_i), .clr_o(clr),
    .resp_valid_o, .resp_word_o(resp)
  );

  trg_pair_router #(.N_TRG(N_TRG), .PAIR_W(PAIR_W)) u_trg (
    .pair_sel_i(cfg_trg_pair_i), .ttl_trg_ni, .ttl_trg_no,
    .usr_trg_out_ni, .usr_trg_in_no
  );

  for (genvar k = 0; k < N_LVL; k++) begin : g_line
    assign bus_irq_no[k] = ~(pend & (lvl == LVL_W'(k + 1)));
  end

  assign stat_pend_o  = pend;
  assign stat_cause_o = cause;
  assign resp_word_o  = resp;

  p_one_line_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~bus_irq_no));
  p_line_release_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(resp_valid_o) |-> &bus_irq_no);
endmodule

// File: tb/sim_irq_cause_top.sv
`timescale 1ns/1ps
module sim_irq_cause_top;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [2:0] cfg_level = 0;
  logic       cfg_rst_en = 0;
  logic [1:0] cfg_pair = 0;
  logic [7:0] lid = 8'h5A;
  logic       irq_n = 1;
  logic [2:0] cause = 0;
  logic       iack = 0;
  logic [2:0] iack_lvl = 0;
  logic [6:0] bus_irq_n;
  logic       pend;
  logic [2:0] st_cause;
  logic       rv;
  logic [15:0] rword;
  logic       brst;
  logic [7:0] trg_in = 8'hFF;
  logic [7:0] trg_out;
  logic       utrg_in;
  logic       utrg_out = 1;

  int n_chk = 0;
  int n_err = 0;

  logic       m_prev = 1, m_pend = 0, m_rv = 0;
  logic [2:0] m_cause = 0, m_lvl = 0;
  logic [15:0] m_word = 0;

  always #2.5 clk = ~clk;

  irq_cause_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_level_i(cfg_level), .cfg_rst_en_i(cfg_rst_en),
    .cfg_trg_pair_i(cfg_pair), .logical_id_i(lid), .usr_irq_ni(irq_n),
    .usr_cause_i(cause), .iack_i(iack), .iack_level_i(iack_lvl),
    .bus_irq_no(bus_irq_n), .stat_pend_o(pend), .stat_cause_o(st_cause),
    .resp_valid_o(rv), .resp_word_o(rword), .board_rst_o(brst),
    .ttl_trg_ni(trg_in), .ttl_trg_no(trg_out), .usr_trg_in_no(utrg_in),
    .usr_trg_out_ni(utrg_out)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [6:0] exp_lines(input logic p, input logic [2:0] l);
    logic [6:0] v = 7'h7F;
    if (p && l != 0) v[l-1] = 1'b0;
    return v;
  endfunction

  function automatic logic [7:0] exp_trg(input logic [1:0] s, input logic o);
    logic [7:0] v = 8'hFF;
    v[2*s+1] = o;
    return v;
  endfunction

  task automatic step(input logic i_n, input logic [2:0] lv, input logic [2:0] c,
                      input logic re, input logic ak, input logic [2:0] al);
    logic fall, hit;
    irq_n = i_n; cfg_level = lv; cause = c; cfg_rst_en = re; iack = ak; iack_lvl = al;
    cfg_pair = 2'($urandom); trg_in = 8'($urandom); utrg_out = 1'($urandom);
    lid = 8'($urandom);
    #1;
    chk("R9 trig in", {15'b0, utrg_in}, {15'b0, trg_in[{cfg_pair, 1'b0}]});
    chk("R10 trig out", {8'b0, trg_out}, {8'b0, exp_trg(cfg_pair, utrg_out)});
    chk("R8 board reset", {15'b0, brst}, {15'b0, re & ~c[2]});
    @(posedge clk);
    fall = m_prev & ~i_n;
    hit  = ak & m_pend & (al == m_lvl);
    m_rv = hit;
    if (hit) begin
      m_word = {5'b0, m_cause, lid};
      m_pend = 0;
    end else if (fall && !m_pend && lv != 0) begin
      m_pend = 1; m_lvl = lv; m_cause = {c[2] & ~re, c[1:0]};
    end
    m_prev = i_n;
    @(negedge clk);
    chk("R2 lines", {9'b0, bus_irq_n}, {9'b0, exp_lines(m_pend, m_lvl)});
    chk("R3 pending", {15'b0, pend}, {15'b0, m_pend});
    chk("R3 cause", {13'b0, st_cause}, {13'b0, m_cause});
    chk("R6 resp valid", {15'b0, rv}, {15'b0, m_rv});
    if (m_rv) chk("R6 resp word", rword, m_word);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R1 lines", {9'b0, bus_irq_n}, 16'h007F);
    chk("R1 pending", {15'b0, pend}, 16'h0);
    chk("R1 valid", {15'b0, rv}, 16'h0);
    chk("R1 cause", {13'b0, st_cause}, 16'h0);
    rst_n = 1;
    @(negedge clk);
    // R2/R3: capture level 3 cause 5
    step(0, 3, 5, 0, 0, 0);
    chk("R2 level3 line", {9'b0, bus_irq_n}, 16'h007B);
    chk("R3 cause5", {13'b0, st_cause}, 16'h5);
    // R5: second pulse while pending
    step(1, 6, 2, 0, 0, 0);
    step(0, 6, 2, 0, 0, 0);
    chk("R5 cause kept", {13'b0, st_cause}, 16'h5);
    chk("R5 line kept", {9'b0, bus_irq_n}, 16'h007B);
    // R7: wrong level ack
    step(0, 6, 2, 0, 1, 2);
    chk("R7 no resp", {15'b0, rv}, 16'h0);
    chk("R7 still pending", {15'b0, pend}, 16'h1);
    // R6: matching ack
    step(0, 6, 2, 0, 1, 3);
    chk("R6 valid", {15'b0, rv}, 16'h1);
    chk("R6 word cause", {13'b0, rword[10:8]}, 16'h5);
    chk("R6 released", {9'b0, bus_irq_n}, 16'h007F);
    step(0, 6, 2, 0, 0, 0);
    chk("R6 single pulse", {15'b0, rv}, 16'h0);
    // R11: held low gives no new interrupt
    repeat (3) step(0, 4, 1, 0, 0, 0);
    chk("R11 no retrigger", {15'b0, pend}, 16'h0);
    // R7: ack with nothing pending
    step(0, 4, 1, 0, 1, 4);
    chk("R7 idle ack", {15'b0, rv}, 16'h0);
    // R4: level 0
    step(1, 0, 3, 0, 0, 0);
    step(0, 0, 3, 0, 0, 0);
    chk("R4 disabled", {15'b0, pend}, 16'h0);
    chk("R4 lines", {9'b0, bus_irq_n}, 16'h007F);
    // R8: reset-enable forces cause bit 2 low
    step(1, 7, 7, 1, 0, 0);
    step(0, 7, 7, 1, 0, 0);
    chk("R8 cause bit2", {13'b0, st_cause}, 16'h3);
    chk("R2 level7 line", {9'b0, bus_irq_n}, 16'h003F);
    step(1, 7, 7, 1, 1, 7);
    chk("R6 id", {8'b0, rword[7:0]}, {8'b0, m_word[7:0]});
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [2:0] al = ($urandom % 2) ? m_lvl : 3'($urandom);
      step(1'(($urandom % 3) != 0), 3'($urandom), 3'($urandom),
           1'(($urandom % 5) == 0), 1'(($urandom % 4) == 0), al);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule